// File: doc/BRIEF.md
# Single-Frame Register Network Port

This block sits on a host register bus and moves whole network frames between that bus and two byte-wide streams. It keeps exactly one receive frame and one transmit frame in local byte memories. The host drains a received frame one byte per read of a data window register. It sends a frame by first loading a byte length and then writing the payload, one byte per write, into a second window. When the final byte is written, the frame is streamed out on a valid/ready byte interface with a last marker.

A small interrupt-control register holds a transmit-done flag, a receive-done flag and a self-test flag. A level interrupt is raised while any of them is set. Done flags are cleared by writes, one per write, in a fixed priority order. A write of the self-test bit resets the whole block and leaves only the self-test flag set. A read of the register clears that flag. A busy flag, set when a frame arrives or leaves and recomputed from the pending flags on every interrupt-control write, decides whether the next incoming frame is taken or thrown away.

Top module: `frame_port`

## Requirements
- R1: After reset, busy reads 1, both byte counts and the interrupt-control register read 0, irq is 0 and tx_valid is 0.
- R2: Offset 0x00 reads DEV_ID[63:32] and offset 0x04 reads DEV_ID[31:0]. The interrupt-info register (0x18), the transmit window (0x20) and every unmapped offset read 0. Bus read data appears on bus_rdata in the cycle after the read strobe.
- R3: irq is 1 exactly when at least one of transmit-done (bit 0), receive-done (bit 1) or self-test (bit 31) of the interrupt-control register (0x14) is set.
- R4: An incoming frame is taken only if busy (0x08, bit 0) is 0 and the receive count (0x0C) is below FRAME_BYTES when its first beat arrives. A taken frame sets busy and stores its bytes from index 0. At its last beat, the receive count becomes the frame length and receive-done is raised.
- R5: Each read of the receive window (0x1C) with a nonzero receive count returns the next stored byte in bits 7:0, moves the read position on and decrements the count. With a count of 0, the read returns 0 and changes nothing.
- R6: A write to the transmit count (0x10) loads the value and restarts the payload position. A value above FRAME_BYTES loads 0.
- R7: Each write to the transmit window (0x20) stores bits 7:0 as the next payload byte, and the write is ignored while the transmit count is 0. The write that reaches the count starts the frame on tx_data, beginning in the next cycle, with tx_last on the final byte. A byte held while tx_ready is 0 stays unchanged. After the final byte is accepted, the transmit count is 0, transmit-done is set and busy is 1.
- R8: A write to interrupt control clears transmit-done if bit 0 is set. Otherwise it clears receive-done if bit 1 is set. Otherwise bit 31 acts as in R9. A value of 0 changes no flag. After every such write, busy equals the OR of the remaining flags.
- R9: Writing bit 31 alone (bits 0 and 1 clear) returns every register to its reset value and then sets the self-test flag. A read of interrupt control returns the current value and then clears the self-test flag.
- R10: Writes to busy, the receive count, interrupt info and the receive window have no effect.
- R11: A frame whose first beat arrives while busy is 1 is dropped in full: the receive count and the stored bytes stay unchanged.
- R12: A frame longer than FRAME_BYTES keeps its first FRAME_BYTES bytes, and the receive count saturates at FRAME_BYTES. While the count equals FRAME_BYTES, new frames are dropped even with busy 0.
- R13: While a frame is streaming out, writes to the transmit count and the transmit window are ignored, and all other registers are still read and written as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt, any flag set |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a receive frame |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Marks the final byte of a transmit frame |
| tx_ready | input | 1 | Sink takes the transmit byte this cycle |

## Verification
A register read takes effect at the clock edge that samples its strobe, and its data sits on bus_rdata for the following cycle. The bench therefore deasserts the strobe and samples the data at the next falling edge. Flags and irq change at the edge that takes the last receive beat, the last transmit byte or an interrupt-control write, so irq is checked at the falling edge just after. The first transmit byte is visible from the falling edge after the emitting write. Each later byte is checked one cycle after the previous handshake, with stalls inserted to show the held byte does not move.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
package fp_pkg;
    localparam int ADDR_W = 6;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ID_HI = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_ID_LO = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BUSY  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_ICR   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_INFO  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RXWIN = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TXWIN = 6'h20;

    localparam int FLAG_TX   = 0;
    localparam int FLAG_RX   = 1;
    localparam int FLAG_TEST = 31;

    typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DROP} rx_mode_e;
endpackage

// File: rtl/fp_byte_ram.sv
`timescale 1ns/1ps
module fp_byte_ram #(
    parameter int DEPTH = 1514,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/frame_port.sv
`timescale 1ns/1ps
module frame_port
    import fp_pkg::*;
#(
    parameter int          FRAME_BYTES = 1514,
    parameter logic [63:0] DEV_ID      = 64'h46524D50_4F525430,
    localparam int CNT_W = $clog2(FRAME_BYTES + 1),
    localparam int AW    = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    typedef struct packed {
        logic              busy;
        logic              f_tx;
        logic              f_rx;
        logic              f_test;
        rx_mode_e          rx_mode;
        logic [CNT_W-1:0]  rx_cnt;
        logic [CNT_W-1:0]  rx_rptr;
        logic [CNT_W-1:0]  rx_wptr;
        logic              tx_send;
        logic [CNT_W-1:0]  tx_cnt;
        logic [CNT_W-1:0]  tx_wptr;
        logic [CNT_W-1:0]  tx_sptr;
        logic [WORD_W-1:0] rdata;
    } state_t;

    localparam state_t RESET_ST = '{busy: 1'b1, rx_mode: RX_IDLE, default: '0};
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BYTES);

    state_t q, d;

    logic          rx_we, tx_we;
    logic [AW-1:0] rx_wa, tx_wa;
    logic [7:0]    rx_rd, tx_rd;
    logic [CNT_W-1:0] rx_next;

    fp_byte_ram #(.DEPTH(FRAME_BYTES)) u_rx_ram (
        .clk   (clk),
        .we    (rx_we),
        .waddr (rx_wa),
        .wdata (rx_data),
        .raddr (AW'(q.rx_rptr)),
        .rdata (rx_rd)
    );

    fp_byte_ram #(.DEPTH(FRAME_BYTES)) u_tx_ram (
        .clk   (clk),
        .we    (tx_we),
        .waddr (tx_wa),
        .wdata (bus_wdata[7:0]),
        .raddr (AW'(q.tx_sptr)),
        .rdata (tx_rd)
    );

    always_comb begin
        d       = q;
        d.rdata = '0;
        rx_we   = 1'b0;
        rx_wa   = '0;
        tx_we   = 1'b0;
        tx_wa   = '0;
        rx_next = q.rx_wptr;

        // outgoing stream: counters settle only after the final byte
        if (q.tx_send && tx_ready) begin
            if (q.tx_sptr == q.tx_cnt - 1'b1) begin
                d.tx_send = 1'b0;
                d.tx_cnt  = '0;
                d.tx_wptr = '0;
                d.f_tx    = 1'b1;
                d.busy    = 1'b1;
            end else begin
                d.tx_sptr = q.tx_sptr + 1'b1;
            end
        end

        if (bus_rd) begin
            unique case (bus_addr)
                OFS_ID_HI: d.rdata = DEV_ID[63:32];
                OFS_ID_LO: d.rdata = DEV_ID[31:0];
                OFS_BUSY:  d.rdata = WORD_W'(q.busy);
                OFS_RXCNT: d.rdata = WORD_W'(q.rx_cnt);
                OFS_TXCNT: d.rdata = WORD_W'(q.tx_cnt);
                OFS_ICR: begin
                    d.rdata            = '0;
                    d.rdata[FLAG_TEST] = q.f_test;
                    d.rdata[FLAG_RX]   = q.f_rx;
                    d.rdata[FLAG_TX]   = q.f_tx;
                    d.f_test           = 1'b0;
                end
                OFS_RXWIN: begin
                    if (q.rx_cnt != '0) begin
                        d.rdata   = WORD_W'(rx_rd);
                        d.rx_cnt  = q.rx_cnt - 1'b1;
                        d.rx_rptr = q.rx_rptr + 1'b1;
                    end
                end
                default: d.rdata = '0;
            endcase
        end

        if (bus_wr) begin
            unique case (bus_addr)
                OFS_TXCNT: begin
                    if (!q.tx_send) begin
                        d.tx_cnt  = (bus_wdata <= WORD_W'(FRAME_BYTES)) ?
                                    bus_wdata[CNT_W-1:0] : '0;
                        d.tx_wptr = '0;
                    end
                end
                OFS_TXWIN: begin
                    if (!q.tx_send && q.tx_cnt != '0) begin
                        tx_we = 1'b1;
                        tx_wa = AW'(q.tx_wptr);
                        if (q.tx_wptr + 1'b1 == q.tx_cnt) begin
                            d.tx_send = 1'b1;
                            d.tx_sptr = '0;
                        end else begin
                            d.tx_wptr = q.tx_wptr + 1'b1;
                        end
                    end
                end
                OFS_ICR: begin
                    if (bus_wdata[FLAG_TX]) begin
                        d.f_tx = 1'b0;
                    end else if (bus_wdata[FLAG_RX]) begin
                        d.f_rx = 1'b0;
                    end else if (bus_wdata[FLAG_TEST]) begin
                        d        = RESET_ST;
                        d.f_test = 1'b1;
                    end
                    d.busy = d.f_tx | d.f_rx | d.f_test;
                end
                default: ;
            endcase
        end

        // incoming stream: decision taken on the first beat
        if (rx_valid) begin
            unique case (d.rx_mode)
                RX_IDLE: begin
                    if (!d.busy && d.rx_cnt < FULL) begin
                        rx_we     = 1'b1;
                        rx_wa     = '0;
                        d.busy    = 1'b1;
                        d.rx_rptr = '0;
                        if (rx_last) begin
                            d.rx_cnt  = CNT_W'(1);
                            d.rx_wptr = '0;
                            d.f_rx    = 1'b1;
                        end else begin
                            d.rx_cnt  = '0;
                            d.rx_wptr = CNT_W'(1);
                            d.rx_mode = RX_RECV;
                        end
                    end else if (!rx_last) begin
                        d.rx_mode = RX_DROP;
                    end
                end
                RX_RECV: begin
                    rx_next = d.rx_wptr;
                    if (d.rx_wptr < FULL) begin
                        rx_we   = 1'b1;
                        rx_wa   = AW'(d.rx_wptr);
                        rx_next = d.rx_wptr + 1'b1;
                    end
                    if (rx_last) begin
                        d.rx_cnt  = rx_next;
                        d.rx_wptr = '0;
                        d.f_rx    = 1'b1;
                        d.rx_mode = RX_IDLE;
                    end else begin
                        d.rx_wptr = rx_next;
                    end
                end
                RX_DROP: begin
                    if (rx_last) begin
                        d.rx_mode = RX_IDLE;
                    end
                end
                default: d.rx_mode = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_ST;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq       = q.f_tx | q.f_rx | q.f_test;
    assign tx_valid  = q.tx_send;
    assign tx_data   = tx_rd;
    assign tx_last   = q.tx_send && (q.tx_sptr == q.tx_cnt - 1'b1);
endmodule

// File: rtl/fp_chk.sv
`timescale 1ns/1ps
module fp_chk
    import fp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              irq,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready
);
    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !bus_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7
    tx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last && !bus_wr) |=> (!tx_valid && irq));

    // R3
    irq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_ICR) |=>
        ((bus_rdata[FLAG_TEST] | bus_rdata[FLAG_RX] | bus_rdata[FLAG_TX]) == $past(irq)));

    // R8
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == OFS_ICR && bus_wdata == '0 && !tx_valid && !rx_valid)
        |=> $stable(irq));
endmodule

bind frame_port fp_chk u_fp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready)
);

// File: tb/test_frame_port.sv
`timescale 1ns/1ps
module test_frame_port;
    import fp_pkg::*;

    localparam int          FRAME = 1514;
    localparam logic [63:0] ID    = 64'h46524D50_4F525430;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic              irq;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_last = 1'b0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_last;
    logic              tx_ready = 1'b0;

    always #2.5 clk = ~clk;

    frame_port #(.FRAME_BYTES(FRAME), .DEV_ID(ID)) i_frame_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic rx_frame(int len, logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            rx_last  = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    typedef struct packed {
        logic              op;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wd;
        logic [31:0]       exp;
        logic [7:0]        req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, OFS_ID_HI, 32'h0, 32'h46524D50, 8'd2},   // R2
        '{1'b1, OFS_ID_LO, 32'h0, 32'h4F525430, 8'd2},   // R2
        '{1'b1, OFS_BUSY,  32'h0, 32'h1,        8'd1},   // R1
        '{1'b1, OFS_RXCNT, 32'h0, 32'h0,        8'd1},   // R1
        '{1'b1, OFS_TXCNT, 32'h0, 32'h0,        8'd1},   // R1
        '{1'b1, OFS_ICR,   32'h0, 32'h0,        8'd1},   // R1
        '{1'b1, OFS_INFO,  32'h0, 32'h0,        8'd2},   // R2
        '{1'b1, OFS_TXWIN, 32'h0, 32'h0,        8'd2},   // R2
        '{1'b1, 6'h3C,     32'h0, 32'h0,        8'd2},   // R2
        '{1'b0, OFS_BUSY,  32'h0, 32'h0,        8'd10},  // R10
        '{1'b1, OFS_BUSY,  32'h0, 32'h1,        8'd10},  // R10
        '{1'b0, OFS_RXCNT, 32'h7, 32'h0,        8'd10},  // R10
        '{1'b1, OFS_RXCNT, 32'h0, 32'h0,        8'd10},  // R10
        '{1'b0, OFS_INFO,  32'h5, 32'h0,        8'd10},  // R10
        '{1'b1, OFS_INFO,  32'h0, 32'h0,        8'd10},  // R10
        '{1'b0, OFS_TXCNT, 32'd2000, 32'h0,     8'd6},   // R6
        '{1'b1, OFS_TXCNT, 32'h0, 32'h0,        8'd6},   // R6
        '{1'b0, OFS_TXCNT, 32'd1515, 32'h0,     8'd6},   // R6
        '{1'b1, OFS_TXCNT, 32'h0, 32'h0,        8'd6},   // R6
        '{1'b0, OFS_TXCNT, 32'd1514, 32'h0,     8'd6},   // R6
        '{1'b1, OFS_TXCNT, 32'h0, 32'd1514,     8'd6},   // R6
        '{1'b0, OFS_TXCNT, 32'd5, 32'h0,        8'd6},   // R6
        '{1'b1, OFS_TXCNT, 32'h0, 32'd5,        8'd6},   // R6
        '{1'b0, OFS_ICR,   32'h80000000, 32'h0, 8'd9},   // R9
        '{1'b1, OFS_ICR,   32'h0, 32'h80000000, 8'd9},   // R9
        '{1'b1, OFS_ICR,   32'h0, 32'h0,        8'd9},   // R9
        '{1'b1, OFS_BUSY,  32'h0, 32'h1,        8'd9},   // R9
        '{1'b1, OFS_TXCNT, 32'h0, 32'h0,        8'd9},   // R9
        '{1'b0, OFS_ICR,   32'h0, 32'h0,        8'd8},   // R8
        '{1'b1, OFS_BUSY,  32'h0, 32'h0,        8'd8}    // R8
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 tx_valid", 32'(tx_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op) begin
                rd(VECS[i].addr, v);
                chk($sformatf("R%0d table %0d", VECS[i].req, i), v, VECS[i].exp);
            end else begin
                wr(VECS[i].addr, VECS[i].wd);
            end
        end
        chk("R3 irq idle", 32'(irq), 32'h0);

        // R4 R5: take a six-byte frame and drain it
        rx_frame(6, 8'h10);
        chk("R3 irq on rx", 32'(irq), 32'h1);
        rd_chk("R4 rx count", OFS_RXCNT, 32'd6);
        rd_chk("R4 busy", OFS_BUSY, 32'h1);
        rd_chk("R4 rx flag", OFS_ICR, 32'h2);
        for (int i = 0; i < 6; i++) rd_chk("R5 rx byte", OFS_RXWIN, 32'(8'h10 + i));
        rd_chk("R5 drained", OFS_RXCNT, 32'h0);
        rd_chk("R5 empty read", OFS_RXWIN, 32'h0);
        rd_chk("R5 empty count", OFS_RXCNT, 32'h0);

        // R11: busy still set, frame dropped
        rx_frame(4, 8'h80);
        rd_chk("R11 dropped", OFS_RXCNT, 32'h0);
        wr(OFS_ICR, 32'h2);
        rd_chk("R8 busy cleared", OFS_BUSY, 32'h0);
        chk("R3 irq low", 32'(irq), 32'h0);

        // R7 R13: four-byte transmit with a stall
        wr(OFS_TXCNT, 32'd4);
        for (int i = 0; i < 4; i++) wr(OFS_TXWIN, 32'h12345600 | 32'(8'hA0 + i));
        chk("R7 tx_valid", 32'(tx_valid), 32'h1);
        chk("R7 first byte", 32'(tx_data), 32'hA0);
        wr(OFS_TXCNT, 32'd9);
        wr(OFS_TXWIN, 32'h99);
        rd_chk("R13 icr serviced", OFS_ICR, 32'h0);
        chk("R7 held byte", 32'(tx_data), 32'hA0);
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R7 tx byte", 32'(tx_data), 32'(8'hA0 + i));
            chk("R7 tx last", 32'(tx_last), 32'(i == 3));
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R7 tx done", 32'(tx_valid), 32'h0);
        chk("R3 irq on tx", 32'(irq), 32'h1);
        rd_chk("R7 tx flag", OFS_ICR, 32'h1);
        rd_chk("R7 tx count", OFS_TXCNT, 32'h0);
        rd_chk("R7 busy", OFS_BUSY, 32'h1);

        // R8: priority between both done flags
        wr(OFS_ICR, 32'h1);
        rx_frame(3, 8'h40);
        tx_ready = 1'b1;
        wr(OFS_TXCNT, 32'd1);
        wr(OFS_TXWIN, 32'h55);
        chk("R7 single byte", 32'(tx_data), 32'h55);
        chk("R7 single last", 32'(tx_last), 32'h1);
        @(negedge clk);
        tx_ready = 1'b0;
        rd_chk("R8 both flags", OFS_ICR, 32'h3);
        wr(OFS_ICR, 32'h3);
        rd_chk("R8 priority", OFS_ICR, 32'h2);
        rd_chk("R8 busy kept", OFS_BUSY, 32'h1);
        wr(OFS_ICR, 32'h2);
        rd_chk("R8 all clear", OFS_ICR, 32'h0);
        rd_chk("R4 count kept", OFS_RXCNT, 32'd3);

        // R12: oversize frame and full gate
        rx_frame(1520, 8'h00);
        rd_chk("R12 saturated", OFS_RXCNT, 32'd1514);
        wr(OFS_ICR, 32'h2);
        rx_frame(2, 8'hC0);
        rd_chk("R12 full gate flag", OFS_ICR, 32'h0);
        rd_chk("R12 full gate count", OFS_RXCNT, 32'd1514);
        rd_chk("R12 byte 0", OFS_RXWIN, 32'h00);
        rd_chk("R12 byte 1", OFS_RXWIN, 32'h01);
        rd_chk("R12 count", OFS_RXCNT, 32'd1512);

        // R7: window write with zero count ignored
        wr(OFS_TXWIN, 32'h77);
        chk("R7 zero count", 32'(tx_valid), 32'h0);
        rd_chk("R7 zero count flag", OFS_ICR, 32'h0);

        // R9: self-test clears receive state
        wr(OFS_ICR, 32'h80000000);
        rd_chk("R9 rx cleared", OFS_RXCNT, 32'h0);
        chk("R3 irq test", 32'(irq), 32'h1);
        rd_chk("R9 test bit", OFS_ICR, 32'h80000000);
        chk("R9 irq after read", 32'(irq), 32'h0);

        // R1: hardware reset mid-run
        wr(OFS_ICR, 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rd_chk("R1 busy after reset", OFS_BUSY, 32'h1);
        rd_chk("R1 icr after reset", OFS_ICR, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule